// File: doc/BRIEF.md
# Stack Instruction Processor Core

This block is a small processor that runs a byte-coded stack instruction set. Every arithmetic and branch operation works on the top of an operand stack. Only the two topmost entries are held in registers, called the top and the second. Entries deeper than that are spilled to a region of data memory and refilled from it. The core keeps a running count of the stack depth and derives the spill-region address from that count.

Instructions are fetched one byte at a time from a byte-wide instruction memory. An opcode is one byte. Instructions that take an address or a label are followed by a two-byte operand, most significant byte first. A separate 32-bit data memory serves the explicit PUSH and POP transfers and the spill and refill traffic. Both memory ports are request streams. The core raises `*_valid` with an address, and the memory accepts the request by raising `*_ready` in the same cycle. Read data must be valid in the cycle of acceptance. While `*_ready` is low the core holds the request unchanged and waits, so the memory can apply back-pressure for any number of cycles. The core never has requests open on both ports at once.

A one-cycle pulse on `start` clears the stack and begins execution at instruction address 0. The core runs until it meets a halt opcode. It then raises `halt` and waits for the next `start`.

Top module: `stack_core`

## Requirements
- R1: Opcode bytes are PUSH 0x01, POP 0x02, ADD 0x03, SUB 0x04, ZERO 0x05, INC 0x06, BEQZ 0x07, BNEZ 0x08, GOTO 0x09 and HALT 0xFF. PUSH, POP, BEQZ, BNEZ and GOTO are followed by a 16-bit operand, high byte first. All other opcodes occupy one byte.
- R2: PUSH reads the data word at the operand address and makes it the new top of stack.
- R3: POP writes the top of stack to the operand address and removes it from the stack.
- R4: ADD replaces the two top values with their sum, modulo 2^32. SUB replaces them with the second minus the top, modulo 2^32.
- R5: ZERO sets the top value to 0 in place. INC adds one to the top value in place, wrapping at 2^32. Neither changes the depth.
- R6: BEQZ removes the top value and jumps to the operand when that value is zero. BNEZ removes it and jumps when it is nonzero. When the condition fails, execution continues with the next instruction.
- R7: GOTO continues execution at its operand address without touching the stack.
- R8: When a PUSH finds depth d ≥ 2, the core first writes the second entry to SPILL_BASE+d−2. When an operation that removes a value starts from depth d > 2, it then reads SPILL_BASE+d−3 back into the second entry. Each of these is exactly one extra data transfer.
- R9: HALT raises `halt` and stops all requests until `start`. A `start` pulse restarts execution at address 0 with an empty stack.
- R10: Opcodes not listed in R1 do nothing and advance execution by one byte.
- R11: A request whose ready is low is held with the same address, write enable and write data on the next cycle. Each accepted transfer happens exactly once. The two ports never have requests open at the same time.
- R12: After reset, `halt`, `imem_valid` and `dmem_valid` are low until `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: clear the stack and run from address 0 |
| halt | output | 1 | High while stopped after a HALT opcode |
| imem_valid | output | 1 | Instruction byte request |
| imem_ready | input | 1 | Instruction memory accepts the request; data valid this cycle |
| imem_addr | output | IAW (16) | Instruction byte address |
| imem_rdata | input | 8 | Instruction byte |
| dmem_valid | output | 1 | Data word request |
| dmem_ready | input | 1 | Data memory accepts the request; read data valid this cycle |
| dmem_we | output | 1 | 1 = write, 0 = read |
| dmem_addr | output | DAW (16) | Data word address |
| dmem_wdata | output | DW (32) | Write data |
| dmem_rdata | input | DW (32) | Read data |

## Verification
The results land at different times. Each instruction byte is taken in the cycle its handshake completes. A stack result only becomes visible when a later POP write is accepted. Spill and refill transfers occur in the accepted data cycles between the fetch of an instruction and the fetch of the next one. For these reasons the bench does not predict per-cycle timing. It drives both ready inputs with random back-pressure, runs each short program until `halt` rises, and only then compares memory contents and transfer counts against values computed arithmetically. Hold-while-stalled and halt-quiet behaviour are cycle-exact properties, so they are checked continuously by the bound assertions.

// File: rtl/stack_core_pkg.sv
package stack_core_pkg;

  localparam logic [7:0] OP_PUSH = 8'h01;
  localparam logic [7:0] OP_POP  = 8'h02;
  localparam logic [7:0] OP_ADD  = 8'h03;
  localparam logic [7:0] OP_SUB  = 8'h04;
  localparam logic [7:0] OP_ZERO = 8'h05;
  localparam logic [7:0] OP_INC  = 8'h06;
  localparam logic [7:0] OP_BEQZ = 8'h07;
  localparam logic [7:0] OP_BNEZ = 8'h08;
  localparam logic [7:0] OP_GOTO = 8'h09;
  localparam logic [7:0] OP_HALT = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FOP, ST_FHI, ST_FLO, ST_EXEC,
    ST_DMEM, ST_SPILL, ST_FILL, ST_HALT
  } seq_state_e;

  typedef enum logic [2:0] {
    SC_NONE, SC_PUSH, SC_POP, SC_POPSET, SC_SET, SC_REFILL, SC_CLEAR
  } stk_cmd_e;

  function automatic logic has_operand(input logic [7:0] op);
    return (op == OP_PUSH) || (op == OP_POP) || (op == OP_BEQZ) ||
           (op == OP_BNEZ) || (op == OP_GOTO);
  endfunction

endpackage

// File: rtl/stack_core_alu.sv
module stack_core_alu
  import stack_core_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [7:0]    op,
  input  logic [DW-1:0] second,
  input  logic [DW-1:0] top,
  output logic [DW-1:0] result
);
  always_comb begin
    unique case (op)
      OP_SUB:  result = second - top;
      OP_INC:  result = top + DW'(1);
      default: result = second + top;
    endcase
  end
endmodule

// File: rtl/stack_core_regs.sv
module stack_core_regs
  import stack_core_pkg::*;
#(
  parameter int DW      = 32,
  parameter int DEPTH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  stk_cmd_e           cmd,
  input  logic [DW-1:0]      val,
  output logic [DW-1:0]      top,
  output logic [DW-1:0]      second,
  output logic [DEPTH_W-1:0] depth
);
  logic [DEPTH_W-1:0] depth_dec;
  assign depth_dec = (depth == '0) ? '0 : depth - DEPTH_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top    <= '0;
      second <= '0;
      depth  <= '0;
    end else begin
      unique case (cmd)
        SC_PUSH: begin
          second <= top;
          top    <= val;
          depth  <= depth + DEPTH_W'(1);
        end
        SC_POP: begin
          top   <= second;
          depth <= depth_dec;
        end
        SC_POPSET: begin
          top   <= val;
          depth <= depth_dec;
        end
        SC_SET:    top    <= val;
        SC_REFILL: second <= val;
        SC_CLEAR:  depth  <= '0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stack_core.sv
module stack_core
  import stack_core_pkg::*;
#(
  parameter int              DW         = 32,
  parameter int              IAW        = 16,
  parameter int              DAW        = 16,
  parameter int              DEPTH_W    = 16,
  parameter logic [DAW-1:0]  SPILL_BASE = DAW'(16'h8000)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           halt,
  output logic           imem_valid,
  input  logic           imem_ready,
  output logic [IAW-1:0] imem_addr,
  input  logic [7:0]     imem_rdata,
  output logic           dmem_valid,
  input  logic           dmem_ready,
  output logic           dmem_we,
  output logic [DAW-1:0] dmem_addr,
  output logic [DW-1:0]  dmem_wdata,
  input  logic [DW-1:0]  dmem_rdata
);
  localparam int OPD_W = 16;

  seq_state_e         state, nxt;
  logic [IAW-1:0]     pc;
  logic [7:0]         op;
  logic [OPD_W-1:0]   opd;
  stk_cmd_e           cmd;
  logic [DW-1:0]      val, top, second, alu_y;
  logic [DEPTH_W-1:0] depth;
  logic               deep2, deep3, take;
  logic [DAW-1:0]     spill_addr;

  stack_core_regs #(.DW(DW), .DEPTH_W(DEPTH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .val(val),
    .top(top), .second(second), .depth(depth)
  );

  stack_core_alu #(.DW(DW)) u_alu (
    .op(op), .second(second), .top(top), .result(alu_y)
  );

  assign deep2      = depth >= DEPTH_W'(2);
  assign deep3      = depth >  DEPTH_W'(2);
  assign spill_addr = SPILL_BASE + DAW'(depth) - DAW'(2);
  assign take       = (op == OP_BEQZ) ? (top == '0) : (top != '0);

  // memory-facing outputs
  assign halt       = (state == ST_HALT);
  assign imem_valid = (state == ST_FOP) || (state == ST_FHI) || (state == ST_FLO);
  assign imem_addr  = pc;
  assign dmem_valid = (state == ST_DMEM) || (state == ST_SPILL) || (state == ST_FILL);
  assign dmem_we    = (state == ST_SPILL) || ((state == ST_DMEM) && (op == OP_POP));
  assign dmem_addr  = (state == ST_DMEM) ? DAW'(opd) : spill_addr;
  assign dmem_wdata = (state == ST_SPILL) ? second : top;

  // sequencer next state and stack command
  always_comb begin
    nxt = state;
    cmd = SC_NONE;
    val = '0;
    unique case (state)
      ST_IDLE, ST_HALT: if (start) begin
        nxt = ST_FOP;
        cmd = SC_CLEAR;
      end
      ST_FOP: if (imem_ready) nxt = has_operand(imem_rdata) ? ST_FHI : ST_EXEC;
      ST_FHI: if (imem_ready) nxt = ST_FLO;
      ST_FLO: if (imem_ready) nxt = ST_EXEC;
      ST_EXEC: begin
        nxt = ST_FOP;
        unique case (op)
          OP_PUSH: nxt = deep2 ? ST_SPILL : ST_DMEM;
          OP_POP:  nxt = ST_DMEM;
          OP_ADD, OP_SUB: begin
            cmd = SC_POPSET;
            val = alu_y;
            nxt = deep3 ? ST_FILL : ST_FOP;
          end
          OP_ZERO: cmd = SC_SET;
          OP_INC: begin
            cmd = SC_SET;
            val = alu_y;
          end
          OP_BEQZ, OP_BNEZ: begin
            cmd = SC_POP;
            nxt = deep3 ? ST_FILL : ST_FOP;
          end
          OP_HALT: nxt = ST_HALT;
          default: ;
        endcase
      end
      ST_SPILL: if (dmem_ready) nxt = ST_DMEM;
      ST_DMEM: if (dmem_ready) begin
        if (op == OP_PUSH) begin
          cmd = SC_PUSH;
          val = dmem_rdata;
          nxt = ST_FOP;
        end else begin
          cmd = SC_POP;
          nxt = deep3 ? ST_FILL : ST_FOP;
        end
      end
      ST_FILL: if (dmem_ready) begin
        cmd = SC_REFILL;
        val = dmem_rdata;
        nxt = ST_FOP;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // program counter, opcode and operand registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pc    <= '0;
      op    <= '0;
      opd   <= '0;
    end else begin
      state <= nxt;
      unique case (state)
        ST_IDLE, ST_HALT: if (start) pc <= '0;
        ST_FOP: if (imem_ready) begin
          op <= imem_rdata;
          pc <= pc + IAW'(1);
        end
        ST_FHI: if (imem_ready) begin
          opd[15:8] <= imem_rdata;
          pc        <= pc + IAW'(1);
        end
        ST_FLO: if (imem_ready) begin
          opd[7:0] <= imem_rdata;
          pc       <= pc + IAW'(1);
        end
        ST_EXEC: begin
          if (op == OP_GOTO) pc <= IAW'(opd);
          else if (((op == OP_BEQZ) || (op == OP_BNEZ)) && take) pc <= IAW'(opd);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stack_core_chk.sv
module stack_core_chk #(
  parameter int DW  = 32,
  parameter int IAW = 16,
  parameter int DAW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           halt,
  input logic           imem_valid,
  input logic           imem_ready,
  input logic [IAW-1:0] imem_addr,
  input logic           dmem_valid,
  input logic           dmem_ready,
  input logic           dmem_we,
  input logic [DAW-1:0] dmem_addr,
  input logic [DW-1:0]  dmem_wdata
);
  assert_imem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_valid && !imem_ready) |=> (imem_valid && $stable(imem_addr)));

  assert_dmem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_valid && !dmem_ready) |=>
      (dmem_valid && $stable(dmem_addr) && $stable(dmem_we) && $stable(dmem_wdata)));

  assert_one_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(imem_valid && dmem_valid));

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!imem_valid && !dmem_valid));

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !start) |=> halt);

  assert_start_leaves_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && start) |=> (!halt && imem_valid));
endmodule

bind stack_core stack_core_chk #(.DW(DW), .IAW(IAW), .DAW(DAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .halt(halt),
  .imem_valid(imem_valid), .imem_ready(imem_ready), .imem_addr(imem_addr),
  .dmem_valid(dmem_valid), .dmem_ready(dmem_ready), .dmem_we(dmem_we),
  .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata)
);

// File: tb/stack_core_tb.sv
module stack_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam logic [15:0] BASE = 16'h8000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        halt;
  logic        imem_valid, imem_ready;
  logic [15:0] imem_addr;
  logic [7:0]  imem_rdata;
  logic        dmem_valid, dmem_ready, dmem_we;
  logic [15:0] dmem_addr;
  logic [31:0] dmem_wdata, dmem_rdata;

  logic [7:0]  imem [0:255];
  logic [31:0] dmem [0:511];
  int wp;
  int nvec = 0, nerr = 0;
  int spill_wr, spill_rd, data_wr, halt_req;
  logic [15:0] max_spill;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_core u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .halt(halt),
    .imem_valid(imem_valid), .imem_ready(imem_ready), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .dmem_valid(dmem_valid), .dmem_ready(dmem_ready),
    .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata)
  );

  function automatic logic [8:0] ix(input logic [15:0] a);
    return {a[15], a[7:0]};
  endfunction

  assign imem_rdata = imem[imem_addr[7:0]];
  assign dmem_rdata = dmem[ix(dmem_addr)];

  // memory model and transfer monitor
  always @(posedge clk) begin
    if (dmem_valid && dmem_ready) begin
      if (dmem_we) begin
        dmem[ix(dmem_addr)] <= dmem_wdata;
        if (dmem_addr >= BASE) begin
          spill_wr <= spill_wr + 1;
          if (dmem_addr > max_spill) max_spill <= dmem_addr;
        end else data_wr <= data_wr + 1;
      end else if (dmem_addr >= BASE) spill_rd <= spill_rd + 1;
    end
    if (halt && imem_valid) halt_req <= halt_req + 1;
  end

  // random back-pressure
  initial begin
    imem_ready = 1'b0;
    dmem_ready = 1'b0;
    forever begin
      @(negedge clk);
      imem_ready = ($urandom % 4) != 0;
      dmem_ready = ($urandom % 3) != 0;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkv(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic clr_prog();
    for (int i = 0; i < 256; i++) imem[i] = 8'hFF;
    wp = 0;
  endtask

  task automatic e1(input logic [7:0] o);
    imem[wp[7:0]] = o;
    wp++;
  endtask

  task automatic e3(input logic [7:0] o, input logic [15:0] a);
    imem[wp[7:0]]       = o;
    imem[(wp + 1) % 256] = a[15:8];
    imem[(wp + 2) % 256] = a[7:0];
    wp += 3;
  endtask

  task automatic run();
    int n;
    @(negedge clk);
    spill_wr = 0; spill_rd = 0; data_wr = 0; max_spill = BASE;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!halt && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(halt, "R9 run ends in halt", 32'(halt), 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) dmem[i] = 32'h0;
    spill_wr = 0; spill_rd = 0; data_wr = 0; halt_req = 0; max_spill = BASE;
    clr_prog();
    repeat (3) @(negedge clk);
    // R12: reset state
    chkv("R12 halt after reset", 32'(halt), 32'd0);
    chkv("R12 imem_valid after reset", 32'(imem_valid), 32'd0);
    chkv("R12 dmem_valid after reset", 32'(dmem_valid), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chkv("R12 idle without start", 32'(imem_valid | dmem_valid | halt), 32'd0);

    // R2 R3 R4 R8 R11: depth sweep with ADD chains
    for (int k = 0; k < 3; k++) begin
      for (int n = 1; n <= 6; n++) begin
        logic [31:0] sum;
        sum = 0;
        clr_prog();
        for (int i = 0; i < n; i++) begin
          dmem[ix(16'h10 + 16'(i))] = 32'(i) * 32'h1111_1111 + 32'(k) * 32'h0F00_0003 + 32'hF000_0000;
          sum += dmem[ix(16'h10 + 16'(i))];
          e3(8'h01, 16'h10 + 16'(i));
        end
        for (int i = 1; i < n; i++) e1(8'h03);
        e3(8'h02, 16'h0040);
        e1(8'hFF);
        run();
        chkv("R4 ADD chain sum", dmem[ix(16'h40)], sum);
        chkv("R8 spill writes", 32'(spill_wr), (n > 2) ? 32'(n - 2) : 32'd0);
        chkv("R8 refill reads", 32'(spill_rd), (n > 2) ? 32'(n - 2) : 32'd0);
        if (n > 2) chkv("R8 highest spill address", 32'(max_spill), 32'(BASE + 16'(n - 3)));
        chkv("R11 data writes exactly once", 32'(data_wr), 32'd1);
      end
    end

    // R4: SUB sweep, shallow
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        logic [31:0] va, vb;
        va = (a == 3) ? 32'hFFFF_FFFF : 32'(a * 7);
        vb = (b == 3) ? 32'h8000_0000 : 32'(b * 5);
        dmem[ix(16'h20)] = va;
        dmem[ix(16'h21)] = vb;
        clr_prog();
        e3(8'h01, 16'h20); e3(8'h01, 16'h21); e1(8'h04); e3(8'h02, 16'h41); e1(8'hFF);
        run();
        chkv("R4 SUB second minus top", dmem[ix(16'h41)], va - vb);
      end
    end

    // R4 R8: SUB with spilled operands
    begin
      logic [31:0] w, x, y, z;
      w = 32'd1000; x = 32'd300; y = 32'd50; z = 32'd7;
      dmem[ix(16'h10)] = w; dmem[ix(16'h11)] = x; dmem[ix(16'h12)] = y; dmem[ix(16'h13)] = z;
      clr_prog();
      for (int i = 0; i < 4; i++) e3(8'h01, 16'h10 + 16'(i));
      e1(8'h04); e1(8'h04); e1(8'h04);
      e3(8'h02, 16'h41); e1(8'hFF);
      run();
      chkv("R4 deep SUB order", dmem[ix(16'h41)], w - (x - (y - z)));
      chkv("R8 deep SUB spills", 32'(spill_wr), 32'd2);
    end

    // R5: ZERO and INC
    for (int t = 0; t < 3; t++) begin
      logic [31:0] v;
      v = (t == 0) ? 32'h0 : (t == 1) ? 32'h1234_5678 : 32'hFFFF_FFFF;
      dmem[ix(16'h22)] = v;
      clr_prog();
      e3(8'h01, 16'h22); e1(8'h06); e1(8'h06); e3(8'h02, 16'h47);
      e3(8'h01, 16'h22); e1(8'h05); e1(8'h06); e3(8'h02, 16'h48);
      e1(8'hFF);
      run();
      chkv("R5 INC twice", dmem[ix(16'h47)], v + 32'd2);
      chkv("R5 ZERO then INC", dmem[ix(16'h48)], 32'd1);
    end

    // R6: conditional branches
    for (int opb = 0; opb < 2; opb++) begin
      for (int t = 0; t < 4; t++) begin
        logic [31:0] v;
        logic tk;
        v = (t == 0) ? 32'h0 : (t == 1) ? 32'h1 : (t == 2) ? 32'h8000_0000 : 32'hFFFF_FFFF;
        tk = (opb == 0) ? (v == 0) : (v != 0);
        dmem[ix(16'h30)] = 32'h5E47_1E11; dmem[ix(16'h31)] = v;
        dmem[ix(16'h32)] = 32'hC1C1_C1C1; dmem[ix(16'h33)] = 32'hC2C2_C2C2;
        dmem[ix(16'h42)] = 32'hDEAD; dmem[ix(16'h43)] = 32'hDEAD;
        clr_prog();
        e3(8'h01, 16'h30); e3(8'h01, 16'h31);
        e3((opb == 0) ? 8'h07 : 8'h08, 16'd19);
        e3(8'h01, 16'h32); e3(8'h02, 16'h42); e3(8'h02, 16'h43); e1(8'hFF);
        e3(8'h01, 16'h33); e3(8'h02, 16'h42); e3(8'h02, 16'h43); e1(8'hFF);
        run();
        chkv("R6 branch path", dmem[ix(16'h42)], tk ? 32'hC2C2_C2C2 : 32'hC1C1_C1C1);
        chkv("R6 branch pops one", dmem[ix(16'h43)], 32'h5E47_1E11);
      end
    end

    // R7: GOTO skips code
    dmem[ix(16'h34)] = 32'hBAD0_BAD0; dmem[ix(16'h35)] = 32'h600D_600D;
    clr_prog();
    e3(8'h09, 16'd10); e3(8'h01, 16'h34); e3(8'h02, 16'h44); e1(8'hFF);
    e3(8'h01, 16'h35); e3(8'h02, 16'h44); e1(8'hFF);
    run();
    chkv("R7 GOTO target", dmem[ix(16'h44)], 32'h600D_600D);

    // R1: operand is high byte first
    dmem[ix(16'h0051)] = 32'hB1B1_0051; dmem[ix(16'h5100)] = 32'hA5A5_5100;
    clr_prog();
    e3(8'h01, 16'h0051); e3(8'h02, 16'h0045); e1(8'hFF);
    run();
    chkv("R1 big-endian operand", dmem[ix(16'h45)], 32'hB1B1_0051);

    // R10: every unused opcode is a one-byte no-op
    for (int o = 0; o < 255; o++) begin
      if (o >= 1 && o <= 9) continue;
      dmem[ix(16'h36)] = 32'h7700_0000 + 32'(o);
      dmem[ix(16'h46)] = 32'h0;
      clr_prog();
      e3(8'h01, 16'h36); e1(8'(o)); e3(8'h02, 16'h46); e1(8'hFF);
      run();
      chkv("R10 unused opcode no effect", dmem[ix(16'h46)], 32'h7700_0000 + 32'(o));
    end

    // R9: halt is quiet; restart empties the stack
    clr_prog();
    e3(8'h01, 16'h10); e3(8'h01, 16'h11); e3(8'h01, 16'h12); e1(8'hFF);
    run();
    halt_req = 0;
    repeat (16) @(negedge clk);
    chkv("R9 no fetch while halted", 32'(halt_req), 32'd0);
    chkv("R9 halt held", 32'(halt), 32'd1);
    dmem[ix(16'h20)] = 32'd40; dmem[ix(16'h21)] = 32'd2;
    clr_prog();
    e3(8'h01, 16'h20); e3(8'h01, 16'h21); e1(8'h03); e3(8'h02, 16'h49); e1(8'hFF);
    run();
    chkv("R9 restart result", dmem[ix(16'h49)], 32'd42);
    chkv("R9 restart empty stack no spill", 32'(spill_wr), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nvec++;
    nerr++;
    $display("FAIL watchdog expired R9 actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule